// File: doc/BRIEF.md
# Block DMA Controller

This block moves a fixed 64-byte block between a main memory and a small peripheral scratch RAM. Software programs a main-memory address through a small register bus, then launches a transfer by writing a peripheral address to one of two start registers. Which start register receives the write selects the direction: one pulls data out of the scratch RAM into main memory, the other pushes main-memory data into the scratch RAM.

After a start, the controller waits a programmable number of cycles and then runs the transfer. A handshake asks the peripheral side to process its commands. When pulling data into main memory, the handshake completes before the copy. When pushing data into the scratch RAM, the copy runs first and the handshake follows. An interrupt marks the end of every transfer. Software clears it by writing any value to the status register. Each memory is driven through a byte-wide port with one cycle of read latency. The copy is pipelined, so one byte moves per cycle.

Top module: `blk_dma_engine`

## Requirements
- R1: Register reads (combinational on `reg_addr`): offset 0x00 returns the main-memory address, 0x04 and 0x10 both return the stored peripheral address, 0x0C returns zero. The status register at 0x18 returns busy in bit 0, the interrupt in bit 12, and zero in every other bit.
- R2: A write to 0x00 stores the low MAW bits of the data. A start write (0x04 or 0x10) stores `data & 0x1FFFFFFF` as the peripheral address.
- R3: Status busy rises on the clock edge that accepts a start write. It stays high for exactly DELAY cycles and clears on the edge where the transfer begins. No memory port is active while busy is high.
- R4: A transfer moves exactly 64 consecutive bytes. The peripheral address is the low PAW bits of the stored peripheral address plus the byte index, wrapping at 2^PAW. The main address is the main-memory address plus the byte index, wrapping at 2^MAW. Bytes just outside the block are left untouched.
- R5: A start write at 0x04 (peripheral to main memory) raises `cmd_req` when the delay ends. It holds `cmd_req` until `cmd_done` is sampled high, and the copy starts on the next cycle. The copied data is the scratch content as it stands after the handshake.
- R6: A start write at 0x10 (main memory to peripheral) copies first. It raises `cmd_req` only after the last byte is written, and holds it until `cmd_done`.
- R7: `irq` rises one cycle after the last step of a transfer (the last copy cycle or the handshake). Any write to 0x18 clears it on the next edge, whatever the data.
- R8: A start write while a transfer is pending or running is ignored. The peripheral address is unchanged and no extra transfer follows.
- R9: An access to any offset other than 0x00, 0x04, 0x0C, 0x10 or 0x18 reads zero and writes nothing. It pulses `reg_err` high for one cycle on the following cycle.
- R10: While `cmd_req` is high, neither memory port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| reg_err | output | 1 | One-cycle pulse after an unmapped access |
| mm_en | output | 1 | Main-memory port enable |
| mm_we | output | 1 | Main-memory write enable |
| mm_addr | output | MAW | Main-memory byte address |
| mm_wdata | output | 8 | Main-memory write byte |
| mm_rdata | input | 8 | Main-memory read byte, one cycle after the request |
| pr_en | output | 1 | Scratch RAM port enable |
| pr_we | output | 1 | Scratch RAM write enable |
| pr_addr | output | PAW | Scratch RAM byte address |
| pr_wdata | output | 8 | Scratch RAM write byte |
| pr_rdata | input | 8 | Scratch RAM read byte, one cycle after the request |
| cmd_req | output | 1 | Command-processing request, held until done |
| cmd_done | input | 1 | Command processing finished |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
A wrong delay count or a wrong phase order shows up within a cycle as a mismatch in status busy, `cmd_req` or `irq` against a reference that steps through the same phases on every clock. The peripheral responder alters the scratch contents during the handshake and checks the scratch RAM when the request arrives. A handshake placed on the wrong side of the copy therefore shows up as wrong data in memory, or as a failed ordering check at the moment `cmd_req` rises. Address or count errors show up as wrong bytes at the block edges, including transfers that wrap both address spaces.

// File: rtl/blk_dma_engine.sv
module blk_dma_engine #(
  parameter int MAW   = 16,
  parameter int PAW   = 9,
  parameter int DELAY = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_err,
  output logic             mm_en,
  output logic             mm_we,
  output logic [MAW-1:0]   mm_addr,
  output logic [7:0]       mm_wdata,
  input  logic [7:0]       mm_rdata,
  output logic             pr_en,
  output logic             pr_we,
  output logic [PAW-1:0]   pr_addr,
  output logic [7:0]       pr_wdata,
  input  logic [7:0]       pr_rdata,
  output logic             cmd_req,
  input  logic             cmd_done,
  output logic             irq
);
  localparam int NB = 64;
  localparam int CW = $clog2(NB + 1);
  localparam int DW = $clog2(DELAY + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CMD, S_COPY, S_DONE} st_t;

  st_t           state;
  logic          to_main, busy, irq_q, err_q;
  logic [MAW-1:0] madr;
  logic [28:0]   padr;
  logic [DW-1:0] wcnt;
  logic [CW-1:0] ccnt;

  wire wr        = reg_sel & reg_we;
  wire hit_madr  = reg_addr == 5'h00;
  wire hit_rdst  = reg_addr == 5'h04;
  wire hit_zero  = reg_addr == 5'h0C;
  wire hit_wrst  = reg_addr == 5'h10;
  wire hit_stat  = reg_addr == 5'h18;
  wire mapped    = hit_madr | hit_rdst | hit_zero | hit_wrst | hit_stat;
  wire start_req = wr & (hit_rdst | hit_wrst);
  wire start     = start_req & (state == S_IDLE);

  logic unused_bits;
  assign unused_bits = ^reg_wdata[31:29];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      to_main <= 1'b0;
      busy    <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      madr    <= '0;
      padr    <= '0;
      wcnt    <= '0;
      ccnt    <= '0;
    end else begin
      err_q <= reg_sel & ~mapped;
      if (wr & hit_madr) madr <= reg_wdata[MAW-1:0];
      if (start) begin
        padr    <= reg_wdata[28:0];
        to_main <= hit_rdst;
        busy    <= 1'b1;
        wcnt    <= '0;
        state   <= S_WAIT;
      end
      case (state)
        S_WAIT: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == DW'(DELAY - 1)) begin
            busy  <= 1'b0;
            ccnt  <= '0;
            state <= to_main ? S_CMD : S_COPY;
          end
        end
        S_CMD: if (cmd_done) begin
          ccnt  <= '0;
          state <= to_main ? S_COPY : S_DONE;
        end
        S_COPY: begin
          ccnt <= ccnt + 1'b1;
          if (ccnt == CW'(NB)) state <= to_main ? S_DONE : S_CMD;
        end
        S_DONE: state <= S_IDLE;
        default: ;
      endcase
      if (state == S_DONE) irq_q <= 1'b1;
      else if (wr & hit_stat) irq_q <= 1'b0;
    end
  end

  wire           rd_ph = (state == S_COPY) && (ccnt < CW'(NB));
  wire           wr_ph = (state == S_COPY) && (ccnt != '0);
  wire [CW-1:0]  didx  = ccnt - 1'b1;

  assign pr_en    = to_main ? rd_ph : wr_ph;
  assign pr_we    = ~to_main & wr_ph;
  assign pr_addr  = padr[PAW-1:0] + (to_main ? PAW'(ccnt) : PAW'(didx));
  assign pr_wdata = mm_rdata;
  assign mm_en    = to_main ? wr_ph : rd_ph;
  assign mm_we    = to_main & wr_ph;
  assign mm_addr  = madr + (to_main ? MAW'(didx) : MAW'(ccnt));
  assign mm_wdata = pr_rdata;
  assign cmd_req  = state == S_CMD;
  assign irq      = irq_q;
  assign reg_err  = err_q;

  always_comb begin
    case (reg_addr)
      5'h00:        reg_rdata = 32'(madr);
      5'h04, 5'h10: reg_rdata = {3'b000, padr};
      5'h18:        reg_rdata = {19'b0, irq_q, 11'b0, busy};
      default:      reg_rdata = 32'h0;
    endcase
  end

  // R10
  no_port_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> !(mm_en || pr_en));
  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> cmd_req);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && state != S_IDLE) |=> $stable(padr));
  // R7
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_stat && state != S_DONE) |=> !irq);
  // R3
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_en || pr_en) |-> !busy);
  // R4
  copy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COPY) |-> (ccnt <= CW'(NB)));
endmodule

// File: tb/test_blk_dma_engine.sv
module test_blk_dma_engine;
  localparam int MAW = 16, PAW = 9, DLY = 16;
  localparam int MSZ = 1 << MAW, PSZ = 1 << PAW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_sel, reg_we, reg_err, mm_en, mm_we, pr_en, pr_we, cmd_req, cmd_done, irq;
  logic [4:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [MAW-1:0] mm_addr;
  logic [PAW-1:0] pr_addr;
  logic [7:0] mm_wdata, mm_rdata, pr_wdata, pr_rdata;

  blk_dma_engine #(.MAW(MAW), .PAW(PAW), .DELAY(DLY)) i_blk_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .mm_en(mm_en), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .pr_en(pr_en), .pr_we(pr_we), .pr_addr(pr_addr), .pr_wdata(pr_wdata), .pr_rdata(pr_rdata),
    .cmd_req(cmd_req), .cmd_done(cmd_done), .irq(irq));

  logic [7:0] mmem [0:MSZ-1];
  logic [7:0] pmem [0:PSZ-1];
  logic [7:0] expb [0:63];

  always @(posedge clk) begin
    if (mm_en) begin
      if (mm_we) mmem[mm_addr] <= mm_wdata; else mm_rdata <= mmem[mm_addr];
    end
    if (pr_en) begin
      if (pr_we) pmem[pr_addr] <= pr_wdata; else pr_rdata <= pmem[pr_addr];
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // peripheral command responder
  bit mode_p2m = 1'b0;
  int cur_m = 0, cur_p = 0, rlat = 0;
  always @(negedge clk) begin
    cmd_done = 1'b0;
    if (cmd_req) begin
      rlat++;
      if (rlat == 1 && !mode_p2m) begin
        int bad = 0;
        for (int i = 0; i < 64; i++)
          if (pmem[(cur_p + i) % PSZ] !== mmem[(cur_m + i) % MSZ]) bad++;
        chk("R6", "scratch filled before cmd_req", bad, 0);
      end
      if (rlat == 3) begin
        cmd_done = 1'b1;
        rlat = 0;
        if (mode_p2m)
          for (int i = 0; i < 64; i++) pmem[(cur_p + i) % PSZ] ^= 8'hA5;
      end
    end else rlat = 0;
  end

  // behavioural reference: 0 idle,1 delay,2 cmd-first,3 copy,4 cmd-after,5 finish
  int m_stage, m_wait, m_copy;
  bit m_busy, m_irq, m_p2m;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_busy = 0; m_irq = 0; m_wait = 0; m_copy = 0; m_p2m = 0;
    end else begin
      bit fin, ack;
      fin = (m_stage == 5);
      ack = reg_sel && reg_we && reg_addr == 5'h18;
      case (m_stage)
        0: if (reg_sel && reg_we && (reg_addr == 5'h04 || reg_addr == 5'h10)) begin
             m_stage = 1; m_wait = DLY; m_busy = 1; m_p2m = (reg_addr == 5'h04);
           end
        1: begin
             m_wait--;
             if (m_wait == 0) begin m_busy = 0; m_copy = 0; m_stage = m_p2m ? 2 : 3; end
           end
        2: if (cmd_done) begin m_stage = 3; m_copy = 0; end
        3: begin m_copy++; if (m_copy == 65) m_stage = m_p2m ? 5 : 4; end
        4: if (cmd_done) m_stage = 5;
        5: m_stage = 0;
        default: ;
      endcase
      if (fin) m_irq = 1; else if (ack) m_irq = 0;
    end
  end

  bit cmp_on = 1'b0;
  always @(posedge clk) begin
    #2;
    if (rst_n && cmp_on) begin
      chk("R7", "irq vs model", irq, m_irq);
      chk("R5", "cmd_req vs model", cmd_req, (m_stage == 2 || m_stage == 4));
      if (!reg_sel) chk("R3", "status busy vs model", reg_rdata[0], m_busy);
      if (cmd_req) chk("R10", "port idle during cmd", mm_en | pr_en, 0);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_we = 0; reg_addr = 5'h18;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 0; reg_addr = 5'h18;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk("R7", "irq raised after transfer", irq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bad;
    rst_n = 0; reg_sel = 0; reg_we = 0; reg_addr = 5'h18; reg_wdata = 0; cmd_done = 0;
    for (int i = 0; i < MSZ; i++) mmem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < PSZ; i++) pmem[i] = 8'(i) ^ 8'h5C;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;

    // reset state
    rd(5'h00, v); chk("R1", "reset main addr", v, 0);
    rd(5'h04, v); chk("R1", "reset periph addr", v, 0);
    rd(5'h18, v); chk("R1", "reset status", v, 0);
    chk("R7", "reset irq", irq, 0);
    chk("R5", "reset cmd_req", cmd_req, 0);

    wr(5'h00, 32'hABCD1234);
    rd(5'h00, v); chk("R2", "main addr masked", v, 32'h1234);
    rd(5'h0C, v); chk("R1", "offset 0x0C reads zero", v, 0);

    // peripheral -> main memory
    mode_p2m = 1; cur_m = 32'h1234; cur_p = 32'h40;
    for (int i = 0; i < 64; i++) expb[i] = pmem[cur_p + i] ^ 8'hA5;
    wr(5'h04, 32'hE0000040);
    rd(5'h18, v); chk("R3", "busy after start", v, 32'h1);
    rd(5'h04, v); chk("R2", "periph addr masked", v, 32'h40);
    rd(5'h10, v); chk("R1", "0x10 mirrors periph addr", v, 32'h40);
    wr(5'h10, 32'h00000100);
    rd(5'h04, v); chk("R8", "start while busy ignored", v, 32'h40);
    wait_irq();
    rd(5'h18, v); chk("R1", "status irq bit12, busy 0", v, 32'h1000);
    bad = 0;
    for (int i = 0; i < 64; i++) if (mmem[cur_m + i] !== expb[i]) bad++;
    chk("R5", "main memory holds post-command scratch", bad, 0);
    chk("R4", "byte below block untouched", mmem[cur_m - 1], 8'((cur_m - 1) * 7 + 3));
    chk("R4", "byte above block untouched", mmem[cur_m + 64], 8'((cur_m + 64) * 7 + 3));
    wr(5'h18, 32'h0);
    chk("R7", "irq cleared by status write", irq, 0);
    repeat (150) @(negedge clk);
    chk("R8", "no extra transfer after ignored start", irq, 0);

    // main memory -> peripheral, both addresses wrap
    mode_p2m = 0; cur_m = 32'hFFE0; cur_p = 32'h1F0;
    for (int i = 0; i < 64; i++) expb[i] = mmem[(cur_m + i) % MSZ];
    wr(5'h00, 32'h0000FFE0);
    wr(5'h10, 32'hFFFFFFF0);
    rd(5'h04, v); chk("R2", "periph addr masked to 29 bits", v, 32'h1FFFFFF0);
    wait_irq();
    bad = 0;
    for (int i = 0; i < 64; i++) if (pmem[(cur_p + i) % PSZ] !== expb[i]) bad++;
    chk("R4", "scratch holds wrapped block", bad, 0);
    chk("R4", "scratch byte after block untouched", pmem[(cur_p + 64) % PSZ], 8'((cur_p + 64) % PSZ) ^ 8'h5C);
    wr(5'h18, 32'hFFFFFFFF);
    chk("R7", "any status data clears irq", irq, 0);

    // unmapped offsets
    rd(5'h08, v); chk("R9", "unmapped read zero", v, 0);
    chk("R9", "err pulse after read", reg_err, 1);
    @(negedge clk); chk("R9", "err pulse one cycle", reg_err, 0);
    wr(5'h14, 32'h12345678);
    chk("R9", "err pulse after write", reg_err, 1);
    rd(5'h00, v); chk("R9", "main addr unchanged", v, 32'hFFE0);
    rd(5'h04, v); chk("R9", "periph addr unchanged", v, 32'h1FFFFFF0);
    repeat (40) @(negedge clk);
    chk("R9", "no transfer from unmapped write", irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule